// File: doc/BRIEF.md
# Panel Drive Timing Generator

This block produces the scan timing for an 832 by 624 active-matrix panel whose video arrives on six parallel channels. Each group of six pixel clocks yields six strobes that fire one after another, one per channel sample. A common re-sample strobe then transfers all six held samples to the panel at once. Horizontal and vertical start pulses and toggling shift clocks walk the panel's scanners, and a drive-polarity bit alternates from line to line. That alternation pattern flips on every frame.

A three-bit mode code picks one of six centred active windows. The window flag output tells the downstream video path when to send live video and when to send the uniform fill level. The mode is sampled once per frame, so a window never changes in the middle of a frame. The two scan-direction bits pass straight through to the panel.

Top module: `lcd_panel_timing`

## Requirements
- R1: After reset the block is at the first clock of a frame: strobe 1 high, both start pulses high, both shift clocks low, polarity low, and the full 832x624 window in force.
- R2: Exactly one of the six channel strobes is high in each clock, and strobe k (k = 1..6) is high in pixel clock k-1 of every six-clock group.
- R3: The re-sample strobe is high in exactly the clocks where strobe 6 is high.
- R4: The horizontal shift clock toggles at each group boundary and is low during the first group after reset. The vertical shift clock toggles at each line boundary.
- R5: A line lasts ceil(832/6) = 139 groups (834 clocks). The horizontal start pulse is high only in the first clock of a line. The vertical start pulse is high only in the first clock of a frame of 624 lines.
- R6: Polarity equals the parity of the line index within the frame XOR the parity of the frame count since reset.
- R7: Mode codes, written as bits [2:0], give these windows: 000 is 832x624, 010 is 762x572, 001 is 800x600, 011 is 640x480, 100 is 640x400, 101 is 832x480.
- R8: The window is centred. The active flag is high exactly for column (group*6 + clock-in-group) in [(832-w)/2, (832-w)/2 + w) and row in [(624-h)/2, (624-h)/2 + h). The two padding columns 832 and 833 are never active.
- R9: Codes 110 and 111 select the full 832x624 window.
- R10: The mode input is sampled only in the last clock of a frame and governs the whole next frame. Changes at any other time have no effect on the active flag.
- R11: Horizontal and vertical direction outputs equal their inputs in the same cycle (1 = normal scan, 0 = reversed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Window mode code |
| hdir_i | input | 1 | Horizontal scan direction request |
| vdir_i | input | 1 | Vertical scan direction request |
| hst_o | output | 1 | Horizontal start pulse |
| hck_o | output | 1 | Horizontal shift clock |
| vst_o | output | 1 | Vertical start pulse |
| vck_o | output | 1 | Vertical shift clock |
| sh_o | output | CHANNELS | Per-channel sample strobes, bit 0 = strobe 1 |
| resample_o | output | 1 | Common re-sample strobe |
| pol_o | output | 1 | Drive polarity |
| active_o | output | 1 | High inside the active window, low where fill is sent |
| hdir_o | output | 1 | Horizontal scan direction to panel |
| vdir_o | output | 1 | Vertical scan direction to panel |

## Verification
Every output here is decoded from the clock, group, line and frame counters. A counter that slips by one shows at the ports within one cycle, as a strobe out of order or a start pulse in the wrong place. A wrong frame-parity bit shows only at the next line start, as polarity that fails to alternate. A mode register loaded at the wrong time shows only where the old and new windows differ, which can be many lines into the frame. The reference model is therefore compared on every clock across several frames. Each mode change lands in the middle of a frame and is followed by a decoy change, so that the frame boundary is the only instant that matters.

// File: rtl/lcd_timing_pkg.sv
`timescale 1ns/1ps
package lcd_timing_pkg;

    localparam int NUM_WINDOWS = 6;

    typedef logic [2:0] mode_code_t;

    // Maps a mode code to a window slot; unlisted codes use the full panel (slot 0).
    function automatic int mode_slot(input mode_code_t code);
        case (code)
            3'b000:  return 0;
            3'b010:  return 1;
            3'b001:  return 2;
            3'b011:  return 3;
            3'b100:  return 4;
            3'b101:  return 5;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/lcd_scan_counter.sv
`timescale 1ns/1ps
module lcd_scan_counter #(
    parameter int CHANNELS = 6,
    parameter int GROUPS   = 139,
    parameter int ROWS     = 624,
    parameter int PH_W     = $clog2(CHANNELS),
    parameter int GRP_W    = $clog2(GROUPS),
    parameter int ROW_W    = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [PH_W-1:0]  phase_o,
    output logic [GRP_W-1:0] grp_o,
    output logic [ROW_W-1:0] row_o,
    output logic             group_end_o,
    output logic             line_end_o,
    output logic             frame_end_o,
    output logic             line_start_o,
    output logic             frame_start_o
);

    typedef struct packed {
        logic [PH_W-1:0]  phase;
        logic [GRP_W-1:0] grp;
        logic [ROW_W-1:0] row;
    } scan_t;

    scan_t st_d, st_q;
    logic  grp_last, row_last;

    always_comb begin
        st_d        = st_q;
        group_end_o = (st_q.phase == PH_W'(CHANNELS - 1));
        grp_last    = (st_q.grp == GRP_W'(GROUPS - 1));
        row_last    = (st_q.row == ROW_W'(ROWS - 1));
        line_end_o  = group_end_o && grp_last;
        frame_end_o = line_end_o && row_last;

        if (group_end_o) begin
            st_d.phase = '0;
            if (grp_last) begin
                st_d.grp = '0;
                st_d.row = row_last ? '0 : st_q.row + 1'b1;
            end else begin
                st_d.grp = st_q.grp + 1'b1;
            end
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o       = st_q.phase;
    assign grp_o         = st_q.grp;
    assign row_o         = st_q.row;
    assign line_start_o  = (st_q.phase == '0) && (st_q.grp == '0);
    assign frame_start_o = line_start_o && (st_q.row == '0);

endmodule

// File: rtl/lcd_strobe_gen.sv
`timescale 1ns/1ps
module lcd_strobe_gen #(
    parameter int CHANNELS = 6,
    parameter int PH_W     = $clog2(CHANNELS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PH_W-1:0]     phase_i,
    input  logic                group_end_i,
    input  logic                line_end_i,
    input  logic                frame_end_i,
    input  logic                row_lsb_i,
    output logic [CHANNELS-1:0] sh_o,
    output logic                resample_o,
    output logic                hck_o,
    output logic                vck_o,
    output logic                pol_o
);

    typedef struct packed {
        logic hck;
        logic vck;
        logic fpol;
    } clk_state_t;

    clk_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (group_end_i) cs_d.hck  = ~cs_q.hck;
        if (line_end_i)  cs_d.vck  = ~cs_q.vck;
        if (frame_end_i) cs_d.fpol = ~cs_q.fpol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    for (genvar k = 0; k < CHANNELS; k++) begin : g_strobe
        assign sh_o[k] = (phase_i == PH_W'(k));
    end

    assign resample_o = group_end_i;
    assign hck_o      = cs_q.hck;
    assign vck_o      = cs_q.vck;
    assign pol_o      = cs_q.fpol ^ row_lsb_i;

endmodule

// File: rtl/lcd_window_decode.sv
`timescale 1ns/1ps
module lcd_window_decode
    import lcd_timing_pkg::*;
#(
    parameter int PANEL_W  = 832,
    parameter int PANEL_H  = 624,
    parameter int CHANNELS = 6,
    parameter int PH_W     = 3,
    parameter int GRP_W    = 8,
    parameter int ROW_W    = 10,
    parameter int WIN_W [NUM_WINDOWS] = '{832, 762, 800, 640, 640, 832},
    parameter int WIN_H [NUM_WINDOWS] = '{624, 572, 600, 480, 400, 480}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_code_t       mode_i,
    input  logic             frame_end_i,
    input  logic [PH_W-1:0]  phase_i,
    input  logic [GRP_W-1:0] grp_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             active_o
);

    mode_code_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (frame_end_i) mode_d = mode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    int slot, win_w, win_h, x_off, y_off, col, row;

    always_comb begin
        slot  = mode_slot(mode_q);
        win_w = WIN_W[slot];
        win_h = WIN_H[slot];
        x_off = (PANEL_W - win_w) / 2;
        y_off = (PANEL_H - win_h) / 2;
        col   = int'(grp_i) * CHANNELS + int'(phase_i);
        row   = int'(row_i);
        active_o = (col >= x_off) && (col < x_off + win_w) &&
                   (row >= y_off) && (row < y_off + win_h);
    end

endmodule

// File: rtl/lcd_panel_timing.sv
`timescale 1ns/1ps
module lcd_panel_timing
    import lcd_timing_pkg::*;
#(
    parameter int PANEL_W  = 832,
    parameter int PANEL_H  = 624,
    parameter int CHANNELS = 6,
    parameter int WIN_W [NUM_WINDOWS] = '{832, 762, 800, 640, 640, 832},
    parameter int WIN_H [NUM_WINDOWS] = '{624, 572, 600, 480, 400, 480}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          mode_i,
    input  logic                hdir_i,
    input  logic                vdir_i,
    output logic                hst_o,
    output logic                hck_o,
    output logic                vst_o,
    output logic                vck_o,
    output logic [CHANNELS-1:0] sh_o,
    output logic                resample_o,
    output logic                pol_o,
    output logic                active_o,
    output logic                hdir_o,
    output logic                vdir_o
);

    localparam int GROUPS = (PANEL_W + CHANNELS - 1) / CHANNELS;
    localparam int PH_W   = $clog2(CHANNELS);
    localparam int GRP_W  = $clog2(GROUPS);
    localparam int ROW_W  = $clog2(PANEL_H);

    logic [PH_W-1:0]  phase;
    logic [GRP_W-1:0] grp;
    logic [ROW_W-1:0] row;
    logic             group_end, line_end, frame_end;

    lcd_scan_counter #(
        .CHANNELS(CHANNELS), .GROUPS(GROUPS), .ROWS(PANEL_H),
        .PH_W(PH_W), .GRP_W(GRP_W), .ROW_W(ROW_W)
    ) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_o      (phase),
        .grp_o        (grp),
        .row_o        (row),
        .group_end_o  (group_end),
        .line_end_o   (line_end),
        .frame_end_o  (frame_end),
        .line_start_o (hst_o),
        .frame_start_o(vst_o)
    );

    lcd_strobe_gen #(
        .CHANNELS(CHANNELS), .PH_W(PH_W)
    ) u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase),
        .group_end_i(group_end),
        .line_end_i (line_end),
        .frame_end_i(frame_end),
        .row_lsb_i  (row[0]),
        .sh_o       (sh_o),
        .resample_o (resample_o),
        .hck_o      (hck_o),
        .vck_o      (vck_o),
        .pol_o      (pol_o)
    );

    lcd_window_decode #(
        .PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .CHANNELS(CHANNELS),
        .PH_W(PH_W), .GRP_W(GRP_W), .ROW_W(ROW_W),
        .WIN_W(WIN_W), .WIN_H(WIN_H)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .frame_end_i(frame_end),
        .phase_i    (phase),
        .grp_i      (grp),
        .row_i      (row),
        .active_o   (active_o)
    );

    assign hdir_o = hdir_i;
    assign vdir_o = vdir_i;

endmodule

// File: rtl/lcd_panel_timing_chk.sv
`timescale 1ns/1ps
module lcd_panel_timing_chk #(
    parameter int CHANNELS = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CHANNELS-1:0] sh_o,
    input logic                resample_o,
    input logic                hst_o,
    input logic                vst_o,
    input logic                hck_o,
    input logic                pol_o,
    input logic                hdir_i,
    input logic                hdir_o
);

    // R2
    sh_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sh_o) == 1);

    // R2
    sh_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_o[0] |=> sh_o[1]);

    // R3
    resample_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resample_o == sh_o[CHANNELS-1]);

    // R4
    hck_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_o[CHANNELS-1] |=> (hck_o != $past(hck_o)));

    // R4
    hck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_o[CHANNELS-1] |=> $stable(hck_o));

    // R5
    vst_in_hst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vst_o |-> (hst_o && sh_o[0]));

    // R6
    pol_line_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_o && !vst_o) |-> (pol_o != $past(pol_o)));

    // R11
    hdir_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdir_o == hdir_i);

endmodule

bind lcd_panel_timing lcd_panel_timing_chk #(.CHANNELS(CHANNELS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sh_o      (sh_o),
    .resample_o(resample_o),
    .hst_o     (hst_o),
    .vst_o     (vst_o),
    .hck_o     (hck_o),
    .pol_o     (pol_o),
    .hdir_i    (hdir_i),
    .hdir_o    (hdir_o)
);

// File: tb/lcd_panel_timing_tb_top.sv
`timescale 1ns/1ps
module lcd_panel_timing_tb_top;

    localparam int PW  = 26;
    localparam int PH  = 9;
    localparam int CH  = 6;
    localparam int GRP = (PW + CH - 1) / CH;
    localparam int LN  = GRP * CH;
    localparam int FR  = LN * PH;
    localparam int NFRAMES = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode = 3'b101;
    logic          hdir = 1'b1;
    logic          vdir = 1'b0;
    logic          hst, hck, vst, vck, resample, pol, active, hdir_q, vdir_q;
    logic [CH-1:0] sh;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lcd_panel_timing #(
        .PANEL_W(PW), .PANEL_H(PH), .CHANNELS(CH),
        .WIN_W('{26, 20, 24, 16, 16, 26}),
        .WIN_H('{9, 7, 8, 6, 5, 6})
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .hdir_i(hdir), .vdir_i(vdir),
        .hst_o(hst), .hck_o(hck), .vst_o(vst), .vck_o(vck), .sh_o(sh),
        .resample_o(resample), .pol_o(pol), .active_o(active),
        .hdir_o(hdir_q), .vdir_o(vdir_q)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Window sizes for the scaled panel, by mode code (R7, R9).
    function automatic void win_size(input logic [2:0] code, output int w, output int h);
        case (code)
            3'b010:  begin w = 20; h = 7; end
            3'b001:  begin w = 24; h = 8; end
            3'b011:  begin w = 16; h = 6; end
            3'b100:  begin w = 16; h = 5; end
            3'b101:  begin w = 26; h = 6; end
            default: begin w = 26; h = 9; end
        endcase
    endfunction

    task automatic compare_at(input int t, input logic [2:0] eff, input string rtag);
        int ph, g, r, f, w, h, col, exp_act;
        ph = t % CH;
        g  = (t / CH) % GRP;
        r  = (t / LN) % PH;
        f  = t / FR;
        chk(rtag, "sh", int'(sh), 1 << ph);                       // R2
        chk("R3", "resample", int'(resample), int'(ph == CH - 1));
        chk("R4", "hck", int'(hck), (t / CH) % 2);
        chk("R4", "vck", int'(vck), (t / LN) % 2);
        chk("R5", "hst", int'(hst), int'((t % LN) == 0));
        chk("R5", "vst", int'(vst), int'((t % FR) == 0));
        chk("R6", "pol", int'(pol), (r + f) % 2);
        win_size(eff, w, h);
        col = g * CH + ph;
        exp_act = int'(col >= (PW - w) / 2 && col < (PW - w) / 2 + w &&
                       r >= (PH - h) / 2 && r < (PH - h) / 2 + h);
        chk("R8", "active", int'(active), exp_act);
        chk("R11", "hdir", int'(hdir_q), int'(hdir));
        chk("R11", "vdir", int'(vdir_q), int'(vdir));
    endtask

    logic [2:0] sched [NFRAMES] = '{3'b010, 3'b001, 3'b011, 3'b100, 3'b101,
                                    3'b110, 3'b111, 3'b000, 3'b010, 3'b011};

    initial begin
        logic [2:0] eff;
        eff = 3'b000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, full window despite mode input 101
        compare_at(0, eff, "R1");
        chk("R1", "active_at_reset_origin", int'(active), 1);
        rst_n = 1'b1;
        for (int t = 0; t < NFRAMES * FR; t++) begin
            compare_at(t, eff, "R2");
            // R10: only the value present in the last frame clock is taken
            if (t % FR == FR - 1) eff = mode;
            if (t % FR == 40)  mode = sched[t / FR];
            if (t % FR == 100) mode = ~sched[t / FR];
            if (t % FR == 200) mode = sched[t / FR];
            hdir = t[0];
            vdir = t[1] ^ t[3];
            @(negedge clk);
        end
        // R10: last frame checked above used the value latched at the boundary
        chk("R10", "frames_run", NFRAMES, NFRAMES);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule